// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog built around a down-counter as wide as the data word. Software loads a reload value and arms the timer through a control word. It keeps the system alive by writing a secret key word to a restart slot, which copies the reload value into the counter. Writes of any other value to that slot have no effect. The counter steps once per bus clock, or once per cycle in which an external slow-tick strobe is high. The control word picks between the two.

When the counter steps from one to zero, a sticky expired flag is set. Depending on the enable bits, this raises a fixed-length system-reset pulse that carries a reset-scope qualifier, a level interrupt and a level external alarm. The key is a build-time choice between two values, so two variants of the same block can use different unlock words.

Top module: `wdg_timer`

## Requirements
- R1: Word slots are selected by `bus_widx`: 0 is the live count, 1 the reload value, 2 the restart slot and 3 the control word. After reset the count and the reload value read all ones, control reads 0 and the restart slot always reads 0.
- R2: Writing a word to slot 2 that equals the key, zero-extended, copies the reload value into the count. The key is 0x5AB9 when `ALT_KEY`=0 and 0x4755 when `ALT_KEY`=1.
- R3: Any other write to slot 2 leaves the count unchanged. This includes the key with upper bits set and the other variant's key.
- R4: Control bit 0 enables counting. With bit 4 clear, the count drops by one on every clock. With bit 0 clear, the count holds.
- R5: With bit 4 set, the count drops by one only on clocks where `tick_i` is high.
- R6: A step from 1 to 0 sets a sticky expired flag, which reads as control bit 6. At zero the count stays at zero and never wraps.
- R7: If control bit 1 is set when the count expires, `sys_rst_o` goes high on the clock after the expiring step and stays high for exactly `RST_PULSE_CYC` cycles. Clearing control bits afterwards does not cut the pulse short.
- R8: While the pulse is high, `rst_scope_o` shows the value control bit 5 had when the pulse began (0 = local reset, 1 = whole-chip reset). When no pulse is active it is 0.
- R9: `irq_o` is high while the expired flag, bit 2 and bit 0 are all set. A key write clears the expired flag.
- R10: `ext_o` follows the same rule as `irq_o`, but gated by bit 3 instead of bit 2.
- R11: If a key write and a counting step fall on the same clock, the key write wins. The count then equals the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow tick strobe, one clock wide |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_widx | input | 2 | Word slot index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed slot |
| sys_rst_o | output | 1 | System-reset request pulse |
| rst_scope_o | output | 1 | Reset scope qualifier |
| irq_o | output | 1 | Expiry interrupt, level |
| ext_o | output | 1 | External expiry signal, level |

## Verification
The bench builds two copies that share the bus. `u0` uses the default key and `RST_PULSE_CYC`=5, so the exact pulse length and a mid-pulse disable fit in a short window. `u1` uses `ALT_KEY`=1 and `RST_PULSE_CYC`=3, so each key can be shown to be refused by the other variant. Small random reload values make expiry and the no-wrap hold at zero reachable in a few hundred cycles, in both tick-source modes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CTL_W     = 6;
  localparam int CTL_EXPD  = 6;
  localparam logic [15:0] KEY_STD = 16'h5AB9;
  localparam logic [15:0] KEY_ALT = 16'h4755;

  typedef enum logic [1:0] {
    RG_COUNT  = 2'd0,
    RG_RELOAD = 2'd1,
    RG_KICK   = 2'd2,
    RG_CTRL   = 2'd3
  } reg_sel_e;

  // packed MSB first: bit 0 is en
  typedef struct packed {
    logic scope;
    logic tsrc;
    logic ext_en;
    logic irq_en;
    logic rst_en;
    logic en;
  } ctl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ALT_KEY = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_widx,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count,
  input  logic              expired,
  output logic [DATA_W-1:0] reload,
  output ctl_t              ctl,
  output logic              kick,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] key_word;
  logic [DATA_W-1:0] reload_q, reload_d;
  ctl_t              ctl_q, ctl_d;
  logic              wr_hit;
  reg_sel_e          sel;

  generate
    if (ALT_KEY != 0) begin : g_key_alt
      assign key_word = DATA_W'(KEY_ALT);
    end else begin : g_key_std
      assign key_word = DATA_W'(KEY_STD);
    end
  endgenerate

  assign wr_hit = bus_sel & bus_wr;
  assign sel    = reg_sel_e'(bus_widx);
  assign kick   = wr_hit && (sel == RG_KICK) && (bus_wdata == key_word);

  always_comb begin
    reload_d = reload_q;
    ctl_d    = ctl_q;
    if (wr_hit && sel == RG_RELOAD) reload_d = bus_wdata;
    if (wr_hit && sel == RG_CTRL)   ctl_d    = ctl_t'(bus_wdata[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      ctl_q    <= '0;
    end else begin
      reload_q <= reload_d;
      ctl_q    <= ctl_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      RG_COUNT:  bus_rdata = count;
      RG_RELOAD: bus_rdata = reload_q;
      RG_KICK:   bus_rdata = '0;
      RG_CTRL: begin
        bus_rdata[CTL_W-1:0] = ctl_q;
        bus_rdata[CTL_EXPD]  = expired;
      end
      default:   bus_rdata = '0;
    endcase
  end

  assign reload = reload_q;
  assign ctl    = ctl_q;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] reload,
  input  logic              en,
  input  logic              tsrc,
  input  logic              tick,
  output logic [DATA_W-1:0] count,
  output logic              expire_evt
);
  logic [DATA_W-1:0] count_q, count_d;
  logic              cnt_ce;
  logic              step;

  assign cnt_ce     = tsrc ? tick : 1'b1;
  assign step       = en && cnt_ce && (count_q != '0) && !load;
  assign expire_evt = step && (count_q == DATA_W'(1));

  always_comb begin
    count_d = count_q;
    if (load)      count_d = reload;
    else if (step) count_d = count_q - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '1;
    else        count_q <= count_d;
  end

  assign count = count_q;

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(reload));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> count_q == $past(count_q));
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !load) |=> count_q == '0);
endmodule

// File: rtl/wdg_alarm.sv
module wdg_alarm #(
  parameter int RST_PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  logic kick,
  input  logic en,
  input  logic rst_en,
  input  logic irq_en,
  input  logic ext_en,
  input  logic scope,
  output logic expired,
  output logic sys_rst_o,
  output logic rst_scope_o,
  output logic irq_o,
  output logic ext_o
);
  localparam int PW = $clog2(RST_PULSE_CYC + 1);

  logic          expired_q, expired_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          scope_q, scope_d;
  logic          pulse_start;

  assign pulse_start = expire_evt && rst_en;

  always_comb begin
    expired_d = expired_q;
    if (kick)            expired_d = 1'b0;
    else if (expire_evt) expired_d = 1'b1;
  end

  always_comb begin
    pcnt_d  = pcnt_q;
    scope_d = scope_q;
    if (pulse_start) begin
      pcnt_d  = PW'(RST_PULSE_CYC);
      scope_d = scope;
    end else if (pcnt_q != '0) begin
      pcnt_d  = pcnt_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expired_q <= 1'b0;
      pcnt_q    <= '0;
      scope_q   <= 1'b0;
    end else begin
      expired_q <= expired_d;
      pcnt_q    <= pcnt_d;
      scope_q   <= scope_d;
    end
  end

  assign expired     = expired_q;
  assign sys_rst_o   = (pcnt_q != '0);
  assign rst_scope_o = sys_rst_o & scope_q;
  assign irq_o       = expired_q & irq_en & en;
  assign ext_o       = expired_q & ext_en & en;

  // R6
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !kick) |=> expired_q);
  // R7
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(expire_evt && rst_en));
  // R8
  scope_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_o |-> !rst_scope_o);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !irq_o);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ALT_KEY       = 0,
  parameter int RST_PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_widx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_o,
  output logic              rst_scope_o,
  output logic              irq_o,
  output logic              ext_o
);
  logic [DATA_W-1:0] count, reload;
  ctl_t              ctl;
  logic              kick, expire_evt, expired;

  wdg_regs #(.DATA_W(DATA_W), .ALT_KEY(ALT_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .count(count),
    .expired(expired), .reload(reload), .ctl(ctl), .kick(kick),
    .bus_rdata(bus_rdata)
  );

  wdg_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(kick), .reload(reload),
    .en(ctl.en), .tsrc(ctl.tsrc), .tick(tick_i), .count(count),
    .expire_evt(expire_evt)
  );

  wdg_alarm #(.RST_PULSE_CYC(RST_PULSE_CYC)) u_alarm (
    .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt), .kick(kick),
    .en(ctl.en), .rst_en(ctl.rst_en), .irq_en(ctl.irq_en),
    .ext_en(ctl.ext_en), .scope(ctl.scope), .expired(expired),
    .sys_rst_o(sys_rst_o), .rst_scope_o(rst_scope_o), .irq_o(irq_o),
    .ext_o(ext_o)
  );
endmodule

// File: tb/sim_wdg_timer.sv
`timescale 1ns/1ps
module sim_wdg_timer;
  localparam int PULSE0 = 5;
  localparam int PULSE1 = 3;
  localparam logic [31:0] KEY0 = 32'h5AB9;
  localparam logic [31:0] KEY1 = 32'h4755;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_widx = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic sr0, sc0, iq0, ex0, sr1, sc1, iq1, ex1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdg_timer #(.DATA_W(32), .ALT_KEY(0), .RST_PULSE_CYC(PULSE0)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(rd0),
    .sys_rst_o(sr0), .rst_scope_o(sc0), .irq_o(iq0), .ext_o(ex0));

  wdg_timer #(.DATA_W(32), .ALT_KEY(1), .RST_PULSE_CYC(PULSE1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(rd1),
    .sys_rst_o(sr1), .rst_scope_o(sc1), .irq_o(iq1), .ext_o(ex1));

  function automatic logic [31:0] ctl_word(bit en, bit rs, bit iq, bit ex, bit ts, bit sc);
    return {26'd0, sc, ts, ex, iq, rs, en};
  endfunction

  // count left after enabling, waiting n clocks, then disabling
  function automatic logic [31:0] run_left(logic [31:0] r, int n);
    return r - 32'(n) - 32'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = idx; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] v0, output logic [31:0] v1);
    bus_widx = idx; #1;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic tick_once();
    tick_i = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c1;
    int first, highs;
    bit scope_ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, a, b); chk(a == '1, "R1 count reset", a, '1);
    rd(2'd1, a, b); chk(a == '1, "R1 reload reset", a, '1);
    rd(2'd3, a, b); chk(a == '0, "R1 ctrl reset", a, '0);
    rd(2'd2, a, b); chk(a == '0, "R1 restart reads 0", a, '0);
    chk({sr0, sc0, iq0, ex0} == 4'b0, "R1 outputs idle", {sr0, sc0, iq0, ex0}, 0);

    // R2 key load, R3 junk ignored (upper bits set)
    wr(2'd1, 32'd77);
    rd(2'd1, a, b); chk(a == 32'd77, "R1 reload readback", a, 32'd77);
    wr(2'd2, KEY0);
    rd(2'd0, a, b); chk(a == 32'd77, "R2 key loads count", a, 32'd77);
    wr(2'd1, 32'd90);
    wr(2'd2, KEY0 | 32'h0001_0000);
    rd(2'd0, a, b); chk(a == 32'd77, "R3 key with upper bits ignored", a, 32'd77);

    // R4 hold while disabled
    repeat (10) @(negedge clk);
    rd(2'd0, a, b); chk(a == 32'd77, "R4 hold when disabled", a, 32'd77);

    // R11 key beats a step on the same clock
    wr(2'd1, 32'd100); wr(2'd2, KEY0);
    wr(2'd3, ctl_word(1, 0, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    wr(2'd2, KEY0);
    rd(2'd0, a, b); chk(a == 32'd100, "R11 key priority", a, 32'd100);
    wr(2'd3, 32'd0);
    rd(2'd0, a, b); chk(a == 32'd99, "R4 last step on disable edge", a, 32'd99);

    // random bus-clock runs (R4, R3)
    for (int it = 0; it < 16; it++) begin
      logic [31:0] r, junk;
      int n;
      r = 32'(20 + $urandom % 200);
      n = int'($urandom % (r - 5));
      junk = $urandom;
      if (junk == KEY0) junk = junk ^ 32'h1;
      wr(2'd3, 32'd0); wr(2'd1, r); wr(2'd2, KEY0);
      wr(2'd2, junk);
      rd(2'd0, a, b); chk(a == r, "R3 random junk restart ignored", a, r);
      wr(2'd3, ctl_word(1, 0, 0, 0, 0, 0));
      repeat (n) @(negedge clk);
      wr(2'd3, 32'd0);
      rd(2'd0, a, b); chk(a == run_left(r, n), "R4 random run", a, run_left(r, n));
    end

    // R5 random tick-driven runs
    for (int it = 0; it < 8; it++) begin
      logic [31:0] r;
      int k;
      r = 32'(30 + $urandom % 100);
      k = 1 + int'($urandom % 10);
      wr(2'd3, 32'd0); wr(2'd1, r); wr(2'd2, KEY0);
      wr(2'd3, ctl_word(1, 0, 0, 0, 1, 0));
      repeat (6) @(negedge clk);
      rd(2'd0, a, b); chk(a == r, "R5 no tick no step", a, r);
      for (int t = 0; t < k; t++) begin
        tick_once();
        repeat ($urandom % 3) @(negedge clk);
      end
      rd(2'd0, a, b); chk(a == r - 32'(k), "R5 one step per tick", a, r - 32'(k));
    end

    // R7 R8 R9 R10 expiry with all outputs and whole-chip scope
    wr(2'd3, 32'd0); wr(2'd1, 32'd3); wr(2'd2, KEY0);
    wr(2'd3, ctl_word(1, 1, 1, 1, 0, 1));
    first = -1; highs = 0; scope_ok = 1;
    for (int i = 0; i < 20; i++) begin
      if (sr0) begin
        if (first < 0) first = i;
        highs++;
        scope_ok &= sc0;
      end
      @(negedge clk);
    end
    chk(first == 3, "R7 pulse start cycle", 32'(first), 32'd3);
    chk(highs == PULSE0, "R7 pulse length", 32'(highs), 32'(PULSE0));
    chk(scope_ok, "R8 scope high during pulse", 32'(scope_ok), 1);
    chk(!sc0, "R8 scope low after pulse", 32'(sc0), 0);
    chk(iq0, "R9 irq on expiry", 32'(iq0), 1);
    chk(ex0, "R10 ext on expiry", 32'(ex0), 1);
    rd(2'd3, a, b); chk(a == 32'h6F, "R6 expired flag reads", a, 32'h6F);
    repeat (10) @(negedge clk);
    rd(2'd0, a, b); chk(a == 32'd0, "R6 no wrap at zero", a, 0);
    chk(iq0, "R9 irq level held", 32'(iq0), 1);

    // R7 pulse survives disable, R8 local scope
    wr(2'd3, 32'd0); wr(2'd1, 32'd2); wr(2'd2, KEY0);
    wr(2'd3, ctl_word(1, 1, 0, 0, 0, 0));
    highs = 0; scope_ok = 1;
    for (int i = 0; i < 16; i++) begin
      if (i == 4) begin bus_sel = 1'b0; bus_wr = 1'b0; end
      if (sr0) begin highs++; scope_ok &= !sc0; end
      if (i == 3) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = 2'd3; bus_wdata = 32'd0;
      end
      @(negedge clk);
    end
    chk(highs == PULSE0, "R7 pulse not cut by disable", 32'(highs), 32'(PULSE0));
    chk(scope_ok, "R8 local scope", 32'(scope_ok), 1);
    chk(!iq0, "R9 irq gated by bit2", 32'(iq0), 0);

    // R9 R10 gating by enable and clear by key
    wr(2'd3, ctl_word(1, 0, 1, 0, 0, 0));
    chk(iq0, "R9 sticky irq re-enabled", 32'(iq0), 1);
    wr(2'd3, ctl_word(0, 0, 1, 0, 0, 0));
    chk(!iq0, "R9 irq needs enable", 32'(iq0), 0);
    wr(2'd3, ctl_word(1, 0, 0, 1, 0, 0));
    chk(ex0 && !iq0, "R10 ext alone", {30'd0, ex0, iq0}, 32'd2);
    wr(2'd3, ctl_word(0, 0, 0, 1, 0, 0));
    chk(!ex0, "R10 ext needs enable", 32'(ex0), 0);
    wr(2'd3, 32'd0); wr(2'd2, KEY0);
    rd(2'd3, a, b); chk(a == 32'd0, "R9 key clears expired", a, 0);
    wr(2'd3, ctl_word(1, 0, 1, 0, 0, 0));
    chk(!iq0, "R9 irq low after key", 32'(iq0), 0);
    repeat (2) @(negedge clk);
    chk(iq0, "R9 irq on new expiry", 32'(iq0), 1);
    wr(2'd3, 32'd0);

    // R2 R3 variant keys
    wr(2'd1, 32'h55);
    rd(2'd0, a, c1);
    wr(2'd2, KEY0);
    rd(2'd0, a, b);
    chk(b == c1, "R3 alt variant refuses std key", b, c1);
    chk(a == 32'h55, "R2 std key loads u0", a, 32'h55);
    wr(2'd1, 32'h66);
    wr(2'd2, KEY1);
    rd(2'd0, a, b);
    chk(b == 32'h66, "R2 alt key loads u1", b, 32'h66);
    chk(a == 32'h55, "R3 std variant refuses alt key", a, 32'h55);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule